// File: doc/BRIEF.md
# Packed Step Queue Sequencer

This block stores a short program of byte-wide step commands and walks through it one command per step tick. Commands are packed two to a 16-bit queue word, so a queue of `NUM_STEPS` commands occupies `NUM_STEPS/2` words. Each fetched command is split into a 4-bit opcode (upper nibble) and a 4-bit option (lower nibble) and presented on an output port for downstream trigger logic, together with the index of the step it came from. One control opcode is decoded locally: two of its options produce single-cycle pulses that turn a step-delay feature off or on.

Software reaches the block through a simple word-wide register port. A control/status word carries an enable bit, a start bit and a sticky error flag. Raising enable rewinds the queue pointer to step zero. Start pauses or resumes stepping without touching the pointer. While the block is enabled, every register except the control/status word is locked. A write that the lock refuses sets the error flag, which software clears by writing a one to it. The pointer can be read back at its own address.

Top module: `step_queue_seq`

## Requirements
- R1: After reset the block is disabled and stopped, the queue pointer and error flag are 0, every queue word reads 0, and `cmd_valid`, `dly_enable_pulse` and `dly_disable_pulse` are low.
- R2: Step k is stored in queue word k/2. An even k uses bits [7:0] of that word and an odd k uses bits [15:8]. Queue word i sits at register address 2+i, and there are NUM_STEPS/2 words.
- R3: A fetched command presents bits [7:4] on `cmd_opcode` and bits [3:0] on `cmd_option`.
- R4: A control/status write that takes bit 15 (enable) from 0 to 1 sets the queue pointer to 0. Writing 1 while already enabled leaves the pointer unchanged.
- R5: Bit 7 (start) of the control/status word pauses or resumes execution and never changes the queue pointer.
- R6: When `step_tick` is high at a clock edge while the block is enabled and started, the outputs show the command at the current pointer for exactly one cycle after that edge: `cmd_valid`=1 and `cmd_step`=pointer. At the same edge the pointer advances by one and wraps from NUM_STEPS-1 to 0.
- R7: A `step_tick` while the block is not both enabled and started produces no command and leaves the pointer unchanged.
- R8: A command with opcode 0 and option 2 raises `dly_disable_pulse`, and opcode 0 with option 6 raises `dly_enable_pulse`. Each pulse is high for the same single cycle as `cmd_valid`. No other command raises either pulse.
- R9: While enabled, a write to any address other than 0 changes nothing and sets the error flag. Control/status writes are still accepted. While disabled, queue writes are accepted and do not set the flag.
- R10: The error flag stays set until a control/status write with bit 0 = 1 clears it. A control/status write with bit 0 = 0 leaves it set.
- R11: Address 0 reads {enable at bit 15, start at bit 7, error at bit 0, zeros elsewhere}. Address 1 reads the queue pointer, zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (0 control/status, 1 pointer, 2+i queue word i) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| step_tick | input | 1 | Request to execute one step |
| cmd_valid | output | 1 | One-cycle strobe: a command was executed |
| cmd_opcode | output | 4 | Opcode of the last executed command |
| cmd_option | output | 4 | Option of the last executed command |
| cmd_step | output | $clog2(NUM_STEPS) | Queue index of the last executed command |
| dly_enable_pulse | output | 1 | One-cycle request to turn step delay on |
| dly_disable_pulse | output | 1 | One-cycle request to turn step delay off |

## Verification
The bench loads every one of the 256 byte values through the queue across 32 programs and checks each fetched command for its opcode, option, step index and delay pulses. A swapped byte lane or nibble order would show up at once, and so would a delay decode on the wrong opcode or option. Every program is run one step past its end to catch a pointer that fails to wrap. Directed cases pause and resume mid-program, re-write enable while already enabled, and tick while enabled but stopped. These catch a design whose start bit rewinds or advances the pointer, or one that rewinds on a level rather than on the rising edge of enable. The lockout cases attempt queue and pointer writes while enabled and then read the words back. A design that lets the write through, forgets to flag it, or clears the flag without the clear bit fails these reads.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Control opcode and its step-delay options
    localparam logic [3:0] OP_CTRL     = 4'h0;
    localparam logic [3:0] OPT_DLY_OFF = 4'h2;
    localparam logic [3:0] OPT_DLY_ON  = 4'h6;

    // Control/status word bit positions
    localparam int CSR_EN_BIT    = 15;
    localparam int CSR_START_BIT = 7;
    localparam int CSR_ERR_BIT   = 0;

    // Register map
    localparam int ADDR_CSR   = 0;
    localparam int ADDR_PTR   = 1;
    localparam int ADDR_QBASE = 2;

    typedef struct packed {
        logic [3:0] opcode;
        logic [3:0] option;
    } step_cmd_t;

endpackage

// File: rtl/seq_queue.sv
module seq_queue #(
    parameter int NUM_WORDS = 4,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [15:0]      wr_data,
    input  logic [IDX_W-1:0] fetch_idx,
    output logic [15:0]      fetch_word,
    input  logic [IDX_W-1:0] sw_idx,
    output logic [15:0]      sw_word
);

    typedef logic [NUM_WORDS-1:0][15:0] qmem_t;

    qmem_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en && (int'(wr_idx) < NUM_WORDS)) begin
            mem_d[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign fetch_word = (int'(fetch_idx) < NUM_WORDS) ? mem_q[fetch_idx] : 16'h0000;
    assign sw_word    = (int'(sw_idx) < NUM_WORDS) ? mem_q[sw_idx] : 16'h0000;

    // R2: a write lands in the addressed word
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_idx) < NUM_WORDS)) |=> (mem_q[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [15:0] word,
    input  logic        sel_hi,
    output step_cmd_t   cmd,
    output logic        is_dly_on,
    output logic        is_dly_off
);

    logic [7:0] cmd_byte;

    always_comb begin
        cmd_byte   = sel_hi ? word[15:8] : word[7:0];
        cmd        = step_cmd_t'(cmd_byte);
        is_dly_on  = (cmd.opcode == OP_CTRL) && (cmd.option == OPT_DLY_ON);
        is_dly_off = (cmd.opcode == OP_CTRL) && (cmd.option == OPT_DLY_OFF);
    end

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int NUM_STEPS = 8,
    parameter int PTR_W     = 3,
    parameter int IDX_W     = 2,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en_bit,
    input  logic              wr_start_bit,
    input  logic              wr_clr_bit,
    input  logic              step_tick,
    input  step_cmd_t         fetch_cmd,
    input  logic              fetch_dly_on,
    input  logic              fetch_dly_off,
    output logic              q_wr_en,
    output logic [IDX_W-1:0]  q_wr_idx,
    output logic              en,
    output logic              start,
    output logic              err,
    output logic [PTR_W-1:0]  ptr,
    output logic              cmd_valid,
    output step_cmd_t         cmd_out,
    output logic [PTR_W-1:0]  cmd_step,
    output logic              dly_on,
    output logic              dly_off
);

    localparam int NUM_WORDS = NUM_STEPS / 2;
    localparam logic [PTR_W-1:0] LAST_STEP = PTR_W'(NUM_STEPS - 1);

    typedef struct packed {
        logic             en;
        logic             start;
        logic             err;
        logic [PTR_W-1:0] ptr;
        logic             cmd_valid;
        step_cmd_t        cmd;
        logic [PTR_W-1:0] step;
        logic             dly_on;
        logic             dly_off;
    } ctrl_state_t;

    ctrl_state_t s_d, s_q;

    logic is_csr;
    logic is_queue;
    logic blocked;
    logic exec;

    always_comb begin
        is_csr   = (reg_addr == ADDR_W'(ADDR_CSR));
        is_queue = (reg_addr >= ADDR_W'(ADDR_QBASE)) &&
                   (reg_addr <  ADDR_W'(ADDR_QBASE + NUM_WORDS));
        blocked  = reg_we && !is_csr && s_q.en;
        exec     = step_tick && s_q.en && s_q.start;

        q_wr_en  = reg_we && is_queue && !s_q.en;
        q_wr_idx = IDX_W'(reg_addr - ADDR_W'(ADDR_QBASE));

        s_d           = s_q;
        s_d.cmd_valid = 1'b0;
        s_d.dly_on    = 1'b0;
        s_d.dly_off   = 1'b0;

        if (exec) begin
            s_d.cmd_valid = 1'b1;
            s_d.cmd       = fetch_cmd;
            s_d.step      = s_q.ptr;
            s_d.dly_on    = fetch_dly_on;
            s_d.dly_off   = fetch_dly_off;
            s_d.ptr       = (s_q.ptr == LAST_STEP) ? '0 : s_q.ptr + 1'b1;
        end

        if (reg_we && is_csr) begin
            s_d.en    = wr_en_bit;
            s_d.start = wr_start_bit;
            if (wr_clr_bit) begin
                s_d.err = 1'b0;
            end
            if (wr_en_bit && !s_q.en) begin
                s_d.ptr = '0;
            end
        end

        if (blocked) begin
            s_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en        = s_q.en;
    assign start     = s_q.start;
    assign err       = s_q.err;
    assign ptr       = s_q.ptr;
    assign cmd_valid = s_q.cmd_valid;
    assign cmd_out   = s_q.cmd;
    assign cmd_step  = s_q.step;
    assign dly_on    = s_q.dly_on;
    assign dly_off   = s_q.dly_off;

    // R4: a rising enable leaves the pointer at step zero
    a_r4_enable_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.en) |-> (s_q.ptr == '0));

    // R5: while enabled, the pointer only moves on a step tick
    a_r5_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.en && !step_tick) |=> $stable(s_q.ptr));

    // R6: after a command the pointer sits one past its step, wrapping
    a_r6_ptr_follows: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cmd_valid |-> (s_q.ptr == ((s_q.step == LAST_STEP) ? '0 : s_q.step + 1'b1)));

    // R7: no command unless enabled and started
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_q.en && s_q.start) |=> !s_q.cmd_valid);

    // R8: delay pulses are exclusive and ride with a command
    a_r8_pulse_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.dly_on || s_q.dly_off) |-> (s_q.cmd_valid && $onehot0({s_q.dly_on, s_q.dly_off})));

    // R9: a refused write raises the error flag
    a_r9_blocked_flags: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> s_q.err);

endmodule

// File: rtl/step_queue_seq.sv
module step_queue_seq
    import seq_pkg::*;
#(
    parameter int NUM_STEPS = 8,
    parameter int ADDR_W    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_we,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [15:0]                  reg_wdata,
    output logic [15:0]                  reg_rdata,
    input  logic                         step_tick,
    output logic                         cmd_valid,
    output logic [3:0]                   cmd_opcode,
    output logic [3:0]                   cmd_option,
    output logic [$clog2(NUM_STEPS)-1:0] cmd_step,
    output logic                         dly_enable_pulse,
    output logic                         dly_disable_pulse
);

    localparam int PTR_W     = $clog2(NUM_STEPS);
    localparam int NUM_WORDS = NUM_STEPS / 2;
    localparam int IDX_W     = PTR_W - 1;

    logic             q_wr_en;
    logic [IDX_W-1:0] q_wr_idx;
    logic [15:0]      fetch_word;
    logic [15:0]      sw_word;
    logic [IDX_W-1:0] sw_idx;
    step_cmd_t        fetch_cmd;
    logic             fetch_dly_on;
    logic             fetch_dly_off;
    logic             en, start, err;
    logic [PTR_W-1:0] ptr;
    step_cmd_t        cmd_out;
    logic             in_queue_range;

    assign sw_idx = IDX_W'(reg_addr - ADDR_W'(ADDR_QBASE));

    seq_queue #(
        .NUM_WORDS (NUM_WORDS),
        .IDX_W     (IDX_W)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (q_wr_en),
        .wr_idx     (q_wr_idx),
        .wr_data    (reg_wdata),
        .fetch_idx  (ptr[PTR_W-1:1]),
        .fetch_word (fetch_word),
        .sw_idx     (sw_idx),
        .sw_word    (sw_word)
    );

    seq_decode u_decode (
        .word       (fetch_word),
        .sel_hi     (ptr[0]),
        .cmd        (fetch_cmd),
        .is_dly_on  (fetch_dly_on),
        .is_dly_off (fetch_dly_off)
    );

    seq_ctrl #(
        .NUM_STEPS (NUM_STEPS),
        .PTR_W     (PTR_W),
        .IDX_W     (IDX_W),
        .ADDR_W    (ADDR_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .wr_en_bit     (reg_wdata[CSR_EN_BIT]),
        .wr_start_bit  (reg_wdata[CSR_START_BIT]),
        .wr_clr_bit    (reg_wdata[CSR_ERR_BIT]),
        .step_tick     (step_tick),
        .fetch_cmd     (fetch_cmd),
        .fetch_dly_on  (fetch_dly_on),
        .fetch_dly_off (fetch_dly_off),
        .q_wr_en       (q_wr_en),
        .q_wr_idx      (q_wr_idx),
        .en            (en),
        .start         (start),
        .err           (err),
        .ptr           (ptr),
        .cmd_valid     (cmd_valid),
        .cmd_out       (cmd_out),
        .cmd_step      (cmd_step),
        .dly_on        (dly_enable_pulse),
        .dly_off       (dly_disable_pulse)
    );

    assign cmd_opcode = cmd_out.opcode;
    assign cmd_option = cmd_out.option;

    // R11: read-back map
    always_comb begin
        in_queue_range = (reg_addr >= ADDR_W'(ADDR_QBASE)) &&
                         (reg_addr <  ADDR_W'(ADDR_QBASE + NUM_WORDS));
        reg_rdata = 16'h0000;
        if (reg_addr == ADDR_W'(ADDR_CSR)) begin
            reg_rdata[CSR_EN_BIT]    = en;
            reg_rdata[CSR_START_BIT] = start;
            reg_rdata[CSR_ERR_BIT]   = err;
        end else if (reg_addr == ADDR_W'(ADDR_PTR)) begin
            reg_rdata = {{(16 - PTR_W){1'b0}}, ptr};
        end else if (in_queue_range) begin
            reg_rdata = sw_word;
        end
    end

endmodule

// File: tb/tb_step_queue_seq.sv
module tb_step_queue_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NSTEPS     = 8;
    localparam int NWORDS     = NSTEPS / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        step_tick = 1'b0;
    logic        cmd_valid;
    logic [3:0]  cmd_opcode;
    logic [3:0]  cmd_option;
    logic [2:0]  cmd_step;
    logic        dly_enable_pulse;
    logic        dly_disable_pulse;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    step_queue_seq #(.NUM_STEPS(NSTEPS), .ADDR_W(4)) dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .reg_we            (reg_we),
        .reg_addr          (reg_addr),
        .reg_wdata         (reg_wdata),
        .reg_rdata         (reg_rdata),
        .step_tick         (step_tick),
        .cmd_valid         (cmd_valid),
        .cmd_opcode        (cmd_opcode),
        .cmd_option        (cmd_option),
        .cmd_step          (cmd_step),
        .dly_enable_pulse  (dly_enable_pulse),
        .dly_disable_pulse (dly_disable_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 4'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        reg_addr = 4'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        step_tick = 1'b1;
        @(negedge clk);
        step_tick = 1'b0;
    endtask

    function automatic logic [7:0] sb(input int p, input int k);
        return 8'(p * 8 + k);
    endfunction

    task automatic load_prog(input int p);
        for (int w = 0; w < NWORDS; w++) begin
            wr(2 + w, {sb(p, 2 * w + 1), sb(p, 2 * w)});
        end
    endtask

    task automatic expect_cmd(input logic [7:0] b, input int idx, input string tag);
        logic exp_on, exp_off;
        exp_on  = (b[7:4] == 4'h0) && (b[3:0] == 4'h6);
        exp_off = (b[7:4] == 4'h0) && (b[3:0] == 4'h2);
        chk(cmd_valid == 1'b1, {tag, " R6 valid"}, int'(cmd_valid), 1);
        chk(cmd_opcode == b[7:4], {tag, " R3 opcode"}, int'(cmd_opcode), int'(b[7:4]));
        chk(cmd_option == b[3:0], {tag, " R3 option"}, int'(cmd_option), int'(b[3:0]));
        chk(int'(cmd_step) == idx, {tag, " R6 step"}, int'(cmd_step), idx);
        chk(dly_enable_pulse == exp_on, {tag, " R8 dly on"}, int'(dly_enable_pulse), int'(exp_on));
        chk(dly_disable_pulse == exp_off, {tag, " R8 dly off"}, int'(dly_disable_pulse), int'(exp_off));
    endtask

    task automatic expect_quiet(input string tag);
        chk(cmd_valid == 1'b0, {tag, " valid low"}, int'(cmd_valid), 0);
        chk(dly_enable_pulse == 1'b0 && dly_disable_pulse == 1'b0, {tag, " pulses low"},
            int'({dly_enable_pulse, dly_disable_pulse}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(0, d); chk(d == 16'h0000, "R1 csr after reset", int'(d), 0);
        rd(1, d); chk(d == 16'h0000, "R1 ptr after reset", int'(d), 0);
        for (int w = 0; w < NWORDS; w++) begin
            rd(2 + w, d); chk(d == 16'h0000, "R1 queue word after reset", int'(d), 0);
        end
        expect_quiet("R1 reset");

        // R2 R3 R6 R8: sweep every byte value through the queue
        for (int p = 0; p < 32; p++) begin
            wr(0, 16'h0000);
            load_prog(p);
            rd(2, d);
            chk(d == {sb(p, 1), sb(p, 0)}, "R2 word 0 packing", int'(d), int'({sb(p, 1), sb(p, 0)}));
            rd(0, d);
            chk(d[0] == 1'b0, "R9 disabled writes leave err clear", int'(d[0]), 0);
            wr(0, 16'h8080);
            rd(1, d); chk(d == 16'h0000, "R4 ptr zero after enable", int'(d), 0);
            rd(0, d); chk(d == 16'h8080, "R11 csr en+start", int'(d), 16'h8080);
            for (int k = 0; k <= NSTEPS; k++) begin
                tick();
                expect_cmd(sb(p, k % NSTEPS), k % NSTEPS, "sweep");
                @(negedge clk);
                expect_quiet("R8 one-cycle strobe");
            end
            rd(1, d); chk(d == 16'h0001, "R6 ptr wrapped to 1", int'(d), 1);
        end

        // R7: enabled but stopped, and started but disabled
        wr(0, 16'h0000);
        wr(0, 16'h8000);
        tick(); expect_quiet("R7 enabled not started");
        rd(1, d); chk(d == 16'h0000, "R7 ptr unchanged", int'(d), 0);
        wr(0, 16'h0080);
        tick(); expect_quiet("R7 started not enabled");
        rd(1, d); chk(d == 16'h0000, "R7 ptr unchanged when disabled", int'(d), 0);

        // R5: pause and resume keep the pointer
        wr(0, 16'h8080);
        tick(); expect_cmd(sb(31, 0), 0, "R5 run");
        tick(); expect_cmd(sb(31, 1), 1, "R5 run");
        wr(0, 16'h8000);
        rd(1, d); chk(d == 16'h0002, "R5 stop keeps ptr", int'(d), 2);
        tick(); expect_quiet("R5 stopped tick");
        rd(1, d); chk(d == 16'h0002, "R5 stopped tick keeps ptr", int'(d), 2);
        wr(0, 16'h8080);
        rd(1, d); chk(d == 16'h0002, "R4 re-enable while enabled keeps ptr", int'(d), 2);
        tick(); expect_cmd(sb(31, 2), 2, "R5 resume");

        // R9 R10: lockout and sticky error
        wr(2, 16'hFFFF);
        rd(2, d);
        chk(d == {sb(31, 1), sb(31, 0)}, "R9 queue write blocked", int'(d), int'({sb(31, 1), sb(31, 0)}));
        rd(0, d); chk(d == 16'h8081, "R9 err set by blocked write", int'(d), 16'h8081);
        tick(); expect_cmd(sb(31, 3), 3, "R10 running with err");
        rd(0, d); chk(d[0] == 1'b1, "R10 err sticky", int'(d[0]), 1);
        wr(0, 16'h8081);
        rd(0, d); chk(d == 16'h8080, "R10 err cleared by bit0", int'(d), 16'h8080);
        wr(1, 16'h0000);
        rd(1, d); chk(d == 16'h0004, "R9 ptr write blocked", int'(d), 4);
        rd(0, d); chk(d[0] == 1'b1, "R9 ptr write sets err", int'(d[0]), 1);
        wr(0, 16'h8080);
        rd(0, d); chk(d[0] == 1'b1, "R10 csr write without bit0 keeps err", int'(d[0]), 1);
        wr(0, 16'h0001);
        rd(0, d); chk(d == 16'h0000, "R10 disable and clear", int'(d), 0);

        // R2: disabled write to the last word, then run it
        wr(5, 16'hA5C3);
        rd(5, d); chk(d == 16'hA5C3, "R2 disabled write accepted", int'(d), 16'hA5C3);
        rd(0, d); chk(d[0] == 1'b0, "R9 disabled write no err", int'(d[0]), 0);
        wr(0, 16'h8080);
        for (int k = 0; k < NSTEPS; k++) begin
            tick();
            if (k == 6) expect_cmd(8'hC3, 6, "R2 even step low byte");
            else if (k == 7) expect_cmd(8'hA5, 7, "R2 odd step high byte");
            else expect_cmd(sb(31, k), k, "R2 rerun");
        end
        rd(1, d); chk(d == 16'h0000, "R6 wrap to zero", int'(d), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule